// File: doc/BRIEF.md
# SD Card Command Issue and Response Capture

This block is the command half of an SD/MMC host controller, with registers that software reaches through a simple 32-bit register port. Software loads a command argument, then writes a command word holding a 6-bit index and flags. If the go bit is set, the block offers the index and argument to a card-side engine over a valid/ready handshake. The engine answers with a stream of response bytes, one per beat, with a last flag and an error flag. The block counts the bytes and checks the count against what the flags asked for. It packs a good response big-endian into four response words and records the outcome in sticky status bits. Each of two interrupt lines is raised when the status word ANDed with that line's own mask is nonzero.

A four-state machine does the sequencing. IDLE goes to ISSUE on an accepted command write. ISSUE presents the command and goes to COLLECT when the engine takes it (command ready). COLLECT accepts response beats and goes to FINISH on a beat flagged last or error. FINISH judges the outcome, updates status and the response words, and returns to IDLE in the next cycle. The command-active status bit is high in every state except IDLE.

Top module: `sdcmd_host`

## Requirements
- R1: The command register (offset 0x0C) reads back the last accepted write. Field layout: index in bits [5:0], response-expected bit 6, long-response bit 7, interrupt-mode bit 8, pending-mode bit 9, go bit 10. The go bit always reads back as 0.
- R2: A command write with the go bit and either bit 8 or bit 9 set issues no command. The command valid output stays low and the status word is unchanged.
- R3: An accepted command drives command valid, with the index from bits [5:0] and the argument register (offset 0x08), and holds all three steady until command ready. Status bit 11 (active) reads 1 from acceptance until the outcome is recorded.
- R4: With bit 6 set and bit 7 clear, a 4-byte response is good. It sets status bit 6 (response end), places the first byte in bits [31:24] of word 0 (offset 0x14), and clears words 1 to 3 (offsets 0x18, 0x1C, 0x20).
- R5: With bit 6 set, a 16-byte response is good whatever bit 7 holds. It fills words 0 to 3 in byte order, big-endian, forces bit 0 of word 3 to 0, and sets status bit 6.
- R6: With bit 6 set, any other byte count, 4 bytes with bit 7 set, or a beat with the error flag, sets status bit 2 (timeout) and leaves the response words unchanged. The error flag sets bit 2 even when no response is expected.
- R7: With bit 6 clear, a response stream that ends without error sets status bit 7 (command sent).
- R8: A write to the clear register (offset 0x38) clears each sticky status bit [10:0] whose write-data bit is 1. It has no effect on bit 11.
- R9: Interrupt line i is high exactly when the status word (offset 0x34) ANDed with mask i (offsets 0x3C, 0x40) is nonzero.
- R10: Reads of word offsets 0xFE0 to 0xFFC return, in order, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0].
- R11: While a command is active, writes to the argument and command registers are ignored.
- R12: After reset, all registers read 0, both interrupt lines are low and command valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| cmd_valid | output | 1 | Command offered to the card engine |
| cmd_ready | input | 1 | Card engine takes the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Block accepts response beats |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final beat of the response |
| rsp_err | input | 1 | Card-side failure; ends the response |
| irq | output | 2 | Maskable interrupt lines |

## Verification
The hardest situations to reach are those in which software acts while a command is in flight. These include a write to the clear register, or to the argument or command register, while the active bit is set. The bench plays the card engine, so it can hold command ready low for as long as it likes. During that window it performs register writes and reads, then releases the handshake and checks the final outcome. Length mismatches come from the same card model sending 4, 7 or 16 bytes, or an error beat, against each flag setting.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int ADDR_W  = 12;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 6;
    localparam int N_IRQ   = 2;
    localparam int CLR_W   = 11;

    // command word fields
    localparam int CB_RESP = 6;
    localparam int CB_LONG = 7;
    localparam int CB_IRQM = 8;
    localparam int CB_PEND = 9;
    localparam int CB_GO   = 10;

    // status bits
    localparam int SB_TIMEOUT = 2;
    localparam int SB_RESPEND = 6;
    localparam int SB_SENT    = 7;
    localparam int SB_ACTIVE  = 11;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_ARG   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RESP0 = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_MASK0 = 12'h03C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_FINISH
    } sdc_state_e;

    typedef struct packed {
        logic timeout;
        logic respend;
        logic sent;
    } sdc_outcome_t;

    function automatic logic [7:0] ident_byte(input logic [2:0] sel);
        logic [7:0] b;
        case (sel)
            3'd0:    b = 8'h81;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
    import sdcmd_pkg::*;
#(
    parameter int RESP_BYTES  = 16,
    parameter int SHORT_BYTES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              want_resp,
    input  logic                              want_long,
    output logic                              cmd_valid,
    input  logic                              cmd_ready,
    input  logic                              rsp_valid,
    output logic                              rsp_ready,
    input  logic [7:0]                        rsp_data,
    input  logic                              rsp_last,
    input  logic                              rsp_err,
    output logic                              busy,
    output logic                              fin,
    output sdc_outcome_t                      outcome,
    output logic                              resp_wr,
    output logic [RESP_BYTES/4-1:0][WORD_W-1:0] resp_words
);
    localparam int WORDS = RESP_BYTES / 4;
    localparam int BI_W  = $clog2(RESP_BYTES);
    localparam int CNT_W = BI_W + 2;
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(RESP_BYTES);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(SHORT_BYTES);

    sdc_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic [7:0]       bytes_q [RESP_BYTES];
    logic             beat;

    assign beat = rsp_valid && rsp_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ISSUE;
            ST_ISSUE:   if (cmd_ready) state_d = ST_COLLECT;
            ST_COLLECT: if (beat && (rsp_last || rsp_err)) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        rsp_ready = (state_q == ST_COLLECT);
        busy      = (state_q != ST_IDLE);
        fin       = (state_q == ST_FINISH);
    end

    // byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < RESP_BYTES; i++) bytes_q[i] <= '0;
        end else if (start && state_q == ST_IDLE) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (beat) begin
            if (rsp_err) begin
                err_q <= 1'b1;
            end else begin
                if (cnt_q < CNT_FULL) bytes_q[cnt_q[BI_W-1:0]] <= rsp_data;
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outcome judged in FINISH
    always_comb begin
        outcome = '0;
        if (state_q == ST_FINISH) begin
            if (err_q)
                outcome.timeout = 1'b1;
            else if (!want_resp)
                outcome.sent = 1'b1;
            else if ((cnt_q == CNT_SHORT && !want_long) || cnt_q == CNT_FULL)
                outcome.respend = 1'b1;
            else
                outcome.timeout = 1'b1;
        end
    end

    assign resp_wr = outcome.respend;

    // big-endian packing
    generate
        for (genvar k = 0; k < WORDS; k++) begin : g_pack
            always_comb begin
                for (int j = 0; j < 4; j++)
                    resp_words[k][WORD_W-1-8*j -: 8] = bytes_q[4*k+j];
                if (k > 0 && cnt_q != CNT_FULL)
                    resp_words[k] = '0;
                if (k == WORDS-1)
                    resp_words[k][0] = 1'b0;
            end
        end
    endgenerate

    // R3: offered command held until taken
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid);

    // R3: after FINISH the machine is idle
    p_fin_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);

    // R6: one outcome at most per command
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(outcome) <= 1);

    // R5: a stored long response ends in a cleared bit
    p_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_wr && cnt_q == CNT_FULL) |-> !resp_words[WORDS-1][0]);

endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
    import sdcmd_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    input  logic                        busy,
    input  logic                        fin,
    input  sdc_outcome_t                outcome,
    input  logic                        resp_wr,
    input  logic [WORDS-1:0][WORD_W-1:0] resp_words,
    output logic                        start,
    output logic                        want_resp,
    output logic                        want_long,
    output logic [IDX_W-1:0]            idx,
    output logic [WORD_W-1:0]           arg,
    output logic [N_IRQ-1:0]            irq
);
    logic [WORD_W-1:0]             arg_q, cmd_q;
    logic [WORDS-1:0][WORD_W-1:0]  resp_q;
    logic [N_IRQ-1:0][WORD_W-1:0]  mask_q;
    logic [CLR_W-1:0]              st_q, st_d;
    logic [WORD_W-1:0]             status_word;
    logic                          wr_arg, wr_cmd, clr_wr;

    assign wr_arg = bus_wr && bus_addr == OFS_ARG && !busy;
    assign wr_cmd = bus_wr && bus_addr == OFS_CMD && !busy;
    assign clr_wr = bus_wr && bus_addr == OFS_CLR;
    assign start  = wr_cmd && bus_wdata[CB_GO] && !bus_wdata[CB_IRQM] && !bus_wdata[CB_PEND];

    assign want_resp = cmd_q[CB_RESP];
    assign want_long = cmd_q[CB_LONG];
    assign idx       = cmd_q[IDX_W-1:0];
    assign arg       = arg_q;

    always_comb begin
        st_d = st_q & ~(clr_wr ? bus_wdata[CLR_W-1:0] : '0);
        if (fin) begin
            st_d[SB_TIMEOUT] = st_d[SB_TIMEOUT] | outcome.timeout;
            st_d[SB_RESPEND] = st_d[SB_RESPEND] | outcome.respend;
            st_d[SB_SENT]    = st_d[SB_SENT]    | outcome.sent;
        end
    end

    assign status_word = WORD_W'(st_q) | (WORD_W'(busy) << SB_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q  <= '0;
            cmd_q  <= '0;
            resp_q <= '0;
            mask_q <= '0;
            st_q   <= '0;
        end else begin
            st_q <= st_d;
            if (wr_arg) arg_q <= bus_wdata;
            if (wr_cmd) begin
                cmd_q        <= bus_wdata;
                cmd_q[CB_GO] <= 1'b0;
            end
            if (resp_wr) resp_q <= resp_words;
            for (int m = 0; m < N_IRQ; m++)
                if (bus_wr && bus_addr == OFS_MASK0 + ADDR_W'(4*m))
                    mask_q[m] <= bus_wdata;
        end
    end

    generate
        for (genvar m = 0; m < N_IRQ; m++) begin : g_irq
            assign irq[m] = |(status_word & mask_q[m]);
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1:5] == '1) begin
            bus_rdata = WORD_W'(ident_byte(bus_addr[4:2]));
        end else begin
            case (bus_addr)
                OFS_ARG:  bus_rdata = arg_q;
                OFS_CMD:  bus_rdata = cmd_q;
                OFS_STAT: bus_rdata = status_word;
                default:  bus_rdata = '0;
            endcase
            for (int k = 0; k < WORDS; k++)
                if (bus_addr == OFS_RESP0 + ADDR_W'(4*k)) bus_rdata = resp_q[k];
            for (int m = 0; m < N_IRQ; m++)
                if (bus_addr == OFS_MASK0 + ADDR_W'(4*m)) bus_rdata = mask_q[m];
        end
    end

    // R8: bits written as one are clear after a clear write
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fin) |=> ((st_q & $past(bus_wdata[CLR_W-1:0])) == '0));

    // R11: register writes during an active command leave state untouched
    p_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && (bus_addr == OFS_CMD || bus_addr == OFS_ARG))
        |=> ($stable(cmd_q) && $stable(arg_q)));

    // R4: response words change only at a good outcome
    p_resp_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_wr |=> $stable(resp_q));

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
    import sdcmd_pkg::*;
#(
    parameter int RESP_BYTES  = 16,
    parameter int SHORT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [7:0]        rsp_data,
    input  logic              rsp_last,
    input  logic              rsp_err,
    output logic [1:0]        irq
);
    localparam int WORDS = RESP_BYTES / 4;

    logic                         start, want_resp, want_long, busy, fin, resp_wr;
    sdc_outcome_t                 outcome;
    logic [WORDS-1:0][WORD_W-1:0] resp_words;

    sdcmd_regs #(.WORDS(WORDS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .fin        (fin),
        .outcome    (outcome),
        .resp_wr    (resp_wr),
        .resp_words (resp_words),
        .start      (start),
        .want_resp  (want_resp),
        .want_long  (want_long),
        .idx        (cmd_index),
        .arg        (cmd_arg),
        .irq        (irq)
    );

    sdcmd_fsm #(.RESP_BYTES(RESP_BYTES), .SHORT_BYTES(SHORT_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .want_resp  (want_resp),
        .want_long  (want_long),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_data   (rsp_data),
        .rsp_last   (rsp_last),
        .rsp_err    (rsp_err),
        .busy       (busy),
        .fin        (fin),
        .outcome    (outcome),
        .resp_wr    (resp_wr),
        .resp_words (resp_words)
    );

    // R2: a go write with interrupt or pending mode offers nothing
    p_noissue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !rsp_ready && bus_wr && bus_addr == OFS_CMD &&
         (bus_wdata[CB_IRQM] || bus_wdata[CB_PEND])) |=> !cmd_valid);

    // R3: index and argument steady while offered
    p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($stable(cmd_index) && $stable(cmd_arg)));

    // R3: command and response phases never overlap
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && rsp_ready));

endmodule

// File: tb/sim_sdcmd_host.sv
module sim_sdcmd_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [7:0]  rsp_data = '0;
    logic        rsp_last = 1'b0;
    logic        rsp_err = 1'b0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdcmd_host u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .rsp_err(rsp_err), .irq(irq)
    );

    localparam logic [11:0] A_ARG = 12'h008, A_CMD = 12'h00C, A_R0 = 12'h014,
                            A_STAT = 12'h034, A_CLR = 12'h038,
                            A_M0 = 12'h03C, A_M1 = 12'h040;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // card engine: take the command, then send n bytes base, base+1, ...
    task automatic card(input int n, input logic [7:0] base, input bit err_end);
        while (!cmd_valid) @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        for (int i = 0; i < n; i++) begin
            rsp_valid = 1'b1;
            rsp_data  = base + 8'(i);
            rsp_last  = (i == n-1);
            rsp_err   = err_end && (i == n-1);
            @(negedge clk);
        end
        rsp_valid = 1'b0; rsp_last = 1'b0; rsp_err = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] pword(input logic [7:0] base, input int k);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[31-8*j -: 8] = base + 8'(4*k+j);
        return w;
    endfunction

    task automatic t_reset;
        chk("R12 cmd_valid", {31'b0, cmd_valid}, 0);
        chk("R12 irq", {30'b0, irq}, 0);
        rd_chk("R12 arg", A_ARG, 0);
        rd_chk("R12 cmd", A_CMD, 0);
        rd_chk("R12 stat", A_STAT, 0);
        rd_chk("R12 resp0", A_R0, 0);
        rd_chk("R12 mask1", A_M1, 0);
    endtask

    task automatic t_ident;
        logic [7:0] id [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) rd_chk("R10 ident", 12'hFE0 + 12'(4*i), {24'b0, id[i]});
    endtask

    task automatic t_readback;
        wr(A_CMD, 32'h0000_02A5);
        rd_chk("R1 cmd readback", A_CMD, 32'h0000_02A5);
        chk("R1 no issue without go", {31'b0, cmd_valid}, 0);
    endtask

    task automatic t_blocked;
        wr(A_CMD, 32'h0000_053F);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 irq mode no valid", {31'b0, cmd_valid}, 0);
        end
        rd_chk("R2 go cleared", A_CMD, 32'h0000_013F);
        wr(A_CMD, 32'h0000_061A);
        repeat (3) @(negedge clk);
        chk("R2 pending mode no valid", {31'b0, cmd_valid}, 0);
        rd_chk("R2 status unchanged", A_STAT, 0);
    endtask

    task automatic t_long(input logic [31:0] cmd, input logic [7:0] base, input string req);
        wr(A_ARG, 32'h0123_4567);
        wr(A_CMD, cmd);
        chk({req, " index"}, {26'b0, cmd_index}, {26'b0, cmd[5:0]});
        chk({req, " arg"}, cmd_arg, 32'h0123_4567);
        card(16, base, 1'b0);
        for (int k = 0; k < 3; k++) rd_chk({req, " word"}, A_R0 + 12'(4*k), pword(base, k));
        rd_chk({req, " word3 lsb"}, A_R0 + 12'd12, pword(base, 3) & ~32'h1);
        rd_chk({req, " status"}, A_STAT, 32'h40);
        rd_chk("R1 go reads zero", A_CMD, cmd & ~32'h400);
        wr(A_CLR, 32'h7FF);
    endtask

    task automatic t_short;
        logic [31:0] v;
        wr(A_ARG, 32'hDEAD_BEEF);
        wr(A_CMD, 32'h0000_0451);
        chk("R3 valid", {31'b0, cmd_valid}, 1);
        chk("R3 index", {26'b0, cmd_index}, 32'h11);
        rd_chk("R3 active bit", A_STAT, 32'h800);
        wr(A_ARG, 32'h0);
        wr(A_CMD, 32'h0000_0455);
        rd_chk("R11 arg kept", A_ARG, 32'hDEAD_BEEF);
        rd_chk("R11 cmd kept", A_CMD, 32'h0000_0051);
        chk("R3 held valid", {31'b0, cmd_valid}, 1);
        chk("R3 held arg", cmd_arg, 32'hDEAD_BEEF);
        chk("R3 held index", {26'b0, cmd_index}, 32'h11);
        card(4, 8'hA1, 1'b0);
        rd_chk("R4 word0", A_R0, 32'hA1A2_A3A4);
        for (int k = 1; k < 4; k++) rd_chk("R4 words cleared", A_R0 + 12'(4*k), 0);
        rd(A_STAT, v);
        chk("R4 status", v, 32'h40);
        wr(A_CLR, 32'h7FF);
    endtask

    task automatic t_bad(input logic [31:0] cmd, input int n, input bit err, input string req);
        wr(A_CMD, cmd);
        card(n, 8'hC0, err);
        rd_chk({req, " timeout"}, A_STAT, 32'h04);
        rd_chk({req, " word0 kept"}, A_R0, pword(8'h50, 0));
        rd_chk({req, " word3 kept"}, A_R0 + 12'd12, pword(8'h50, 3) & ~32'h1);
        wr(A_CLR, 32'h7FF);
    endtask

    task automatic t_noresp_clear_irq;
        wr(A_CMD, 32'h0000_0407);
        card(1, 8'h00, 1'b0);
        rd_chk("R7 sent", A_STAT, 32'h80);
        wr(A_CMD, 32'h0000_0408);
        card(2, 8'h00, 1'b1);
        rd_chk("R6 err without resp", A_STAT, 32'h84);
        wr(A_CLR, 32'h0000_0004);
        rd_chk("R8 selective clear", A_STAT, 32'h80);
        wr(A_M0, 32'h0000_0080);
        wr(A_M1, 32'h0000_0004);
        chk("R9 irq one line", {30'b0, irq}, 32'h1);
        rd_chk("R9 mask1 readback", A_M1, 32'h4);
        wr(A_M1, 32'h0000_0800);
        wr(A_CMD, 32'h0000_0409);
        chk("R9 irq on active", {30'b0, irq}, 32'h3);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd_chk("R8 active bit kept", A_STAT, 32'h800);
        chk("R9 irq after clear", {30'b0, irq}, 32'h2);
        card(1, 8'h00, 1'b0);
        rd_chk("R7 sent again", A_STAT, 32'h80);
        chk("R9 irq idle", {30'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_readback();
        t_blocked();
        t_long(32'h0000_04C2, 8'h30, "R5 long");
        t_short();
        t_long(32'h0000_0443, 8'h50, "R5 long flag clear");
        t_bad(32'h0000_04C4, 4, 1'b0, "R6 short with long");
        t_bad(32'h0000_0445, 7, 1'b0, "R6 odd length");
        t_bad(32'h0000_0446, 3, 1'b1, "R6 error beat");
        t_noresp_clear_irq();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule